// File: doc/BRIEF.md
# Active Priority Tracker

This block keeps the record of nested, in-service interrupts for a single processor interface of an interrupt controller. Instead of remembering the identities of interrupts that were preempted, it holds two bitmaps with one bit per preemption level. One bitmap belongs to group 0 and the other to group 1. The running priority the interface reports is always derived from these bits.

An acknowledge strobe carries the group priority and the group of the interrupt being taken. The block marks that interrupt's preemption level in the matching bitmap. On the next cycle it reports the supplied priority as the running priority.

A completion strobe names an interrupt number, its group and whether the access was secure. When the completion is accepted, the block drops the most urgent entry of the named group: the lowest-numbered set bit in that group's bitmap. It then rebuilds the running priority from whatever bits remain in either bitmap. When nothing remains, the tracker reports the idle code 0x100.

Top module: `active_prio_tracker`

## Requirements
- R1: After reset both bitmaps are empty, `run_prio` is 0x100 and `idle_o` is 1.
- R2: An acknowledge strobe makes `run_prio` equal to the zero-extended `ack_prio` on the next cycle, and `idle_o` goes to 0.
- R3: An acknowledge sets the bit at preemption level `ack_prio >> (MIN_BPR+1)`. With the default of 8 priority bits and MIN_BPR 0 there are 128 levels, held as 4 words of 32. The bit goes to the group-1 bitmap when `ack_grp1` is 1 and HAS_GROUPS is 1, and to the group-0 bitmap otherwise.
- R4: An accepted completion clears the lowest set bit of the named group's bitmap. If that bitmap is empty, nothing is cleared. On the next cycle `run_prio` is the lowest level still set in either bitmap, shifted left by MIN_BPR+1.
- R5: If no bit remains after an accepted completion, `run_prio` returns to 0x100 and `idle_o` to 1.
- R6: A completion that arrives while `run_prio` is 0x100 is ignored.
- R7: A completion whose `eoi_irq` is NUM_IRQ (default 96) or more is ignored. One at NUM_IRQ-1 is accepted.
- R8: With SEC_EXT set, a completion with `eoi_secure` 0 that names group 0 is ignored. A non-secure completion that names group 1 is accepted.
- R9: When acknowledge and completion strobes occur in the same cycle, the acknowledge is performed and the completion is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_valid | input | 1 | One-cycle acknowledge strobe |
| ack_prio | input | PRIO_W | Group priority of the interrupt being activated |
| ack_grp1 | input | 1 | Interrupt being activated belongs to group 1 |
| eoi_valid | input | 1 | One-cycle completion strobe |
| eoi_irq | input | IRQ_W | Interrupt number named by the completion |
| eoi_grp1 | input | 1 | Completed interrupt belongs to group 1 |
| eoi_secure | input | 1 | Completion came from a secure access |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| idle_o | output | 1 | No interrupt is in service |

## Verification
Every one of the 128 preemption levels is activated alone and then completed. Alternating groups and odd priorities across this sweep show that the low priority bit is dropped when the level is formed, and that each level returns the tracker to idle. A nested stack that mixes both groups, and puts two interrupts on the same level in different banks, shows that completion pops from the named bank only and that the rebuilt priority spans both banks. Completion of a group whose bank is empty shows recomputation without a pop. Further cases cover the edge interrupt number, the non-secure group-0 case and the same-cycle strobe case; each of these is followed by a valid completion, so the bench can tell a truly ignored request from one that altered the bitmaps.

// File: rtl/apt_pkg.sv
package apt_pkg;

   typedef enum logic [1:0] {
      APT_HOLD     = 2'd0,
      APT_ACTIVATE = 2'd1,
      APT_COMPLETE = 2'd2
   } apt_op_e;

   // Idle code of the running priority: one above every legal priority.
   function automatic int apt_idle_code(input int prio_w);
      return 1 << prio_w;
   endfunction

endpackage

// File: rtl/apt_lsb_find.sv
// Finds the lowest set bit of a vector, scanning 32-bit words in
// ascending order and taking the first word that is non-zero.
module apt_lsb_find #(
   parameter int W     = 128,
   parameter int IDX_W = 7
) (
   input  logic [W-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   localparam int NW = (W + 31) / 32;
   localparam int PW = NW * 32;
   localparam int FW = $clog2(PW);

   initial begin
      assert ((1 << IDX_W) >= W) else $error("apt_lsb_find: IDX_W too narrow");
   end

   logic [PW-1:0]   padded;
   logic [NW-1:0]   w_nz;
   logic [NW*5-1:0] w_pos_flat;
   logic [FW-1:0]   full;

   assign padded = PW'(vec);

   genvar w;
   for (w = 0; w < NW; w++) begin : g_word
      logic [4:0] pos;
      always_comb begin
         pos = '0;
         for (int b = 31; b >= 0; b--) begin
            if (padded[w*32+b]) pos = 5'(b);
         end
      end
      assign w_nz[w]             = |padded[w*32 +: 32];
      assign w_pos_flat[w*5 +: 5] = pos;
   end

   always_comb begin
      full = '0;
      for (int i = NW - 1; i >= 0; i--) begin
         if (w_nz[i]) full = FW'(i * 32) + FW'(w_pos_flat[i*5 +: 5]);
      end
   end

   assign found = |w_nz;
   assign idx   = IDX_W'(full);

endmodule

// File: rtl/apt_bank.sv
// One bitmap of in-service preemption levels.
module apt_bank #(
   parameter int NLEV  = 128,
   parameter int LVL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [LVL_W-1:0] set_lvl,
   input  logic             clr_en,
   output logic [NLEV-1:0]  q,
   output logic [NLEV-1:0]  d
);
   always_comb begin
      d = q;
      if (set_en) begin
         d[set_lvl] = 1'b1;
      end else if (clr_en) begin
         d = q & (q - NLEV'(1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/active_prio_tracker.sv
module active_prio_tracker
   import apt_pkg::*;
#(
   parameter int PRIO_W     = 8,
   parameter int MIN_BPR    = 0,
   parameter int NUM_IRQ    = 96,
   parameter int IRQ_W      = 10,
   parameter bit HAS_GROUPS = 1'b1,
   parameter bit SEC_EXT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_valid,
   input  logic [PRIO_W-1:0] ack_prio,
   input  logic              ack_grp1,
   input  logic              eoi_valid,
   input  logic [IRQ_W-1:0]  eoi_irq,
   input  logic              eoi_grp1,
   input  logic              eoi_secure,
   output logic [PRIO_W:0]   run_prio,
   output logic              idle_o
);
   localparam int SHIFT = MIN_BPR + 1;
   localparam int LVL_W = PRIO_W - SHIFT;
   localparam int NLEV  = 1 << LVL_W;
   localparam logic [PRIO_W:0] IDLE = (PRIO_W+1)'(apt_idle_code(PRIO_W));

   initial begin
      assert (LVL_W >= 1) else $error("MIN_BPR leaves no preemption levels");
      assert (NUM_IRQ >= 1 && NUM_IRQ <= (1 << IRQ_W)) else $error("NUM_IRQ does not fit IRQ_W");
   end

   logic             ack_bank;
   logic             eoi_bank;
   logic             eoi_ok;
   logic [LVL_W-1:0] ack_lvl;
   logic [NLEV-1:0]  bank_q [2];
   logic [NLEV-1:0]  bank_d [2];
   logic             low_found;
   logic [LVL_W-1:0] low_lvl;
   logic [PRIO_W:0]  run_q;
   logic [PRIO_W:0]  run_d;
   apt_op_e          op;

   // Group steering variant
   if (HAS_GROUPS) begin : g_grouped
      assign ack_bank = ack_grp1;
      assign eoi_bank = eoi_grp1;
   end else begin : g_single
      assign ack_bank = 1'b0;
      assign eoi_bank = 1'b0;
   end

   assign ack_lvl = ack_prio[PRIO_W-1:SHIFT];

   // Completion acceptance: in range, something active, security filter
   logic irq_in_range;
   logic sec_block;
   assign irq_in_range = ({1'b0, eoi_irq} < (IRQ_W+1)'(NUM_IRQ));
   assign sec_block    = SEC_EXT && !eoi_secure && !eoi_bank;
   assign eoi_ok       = eoi_valid && !ack_valid && irq_in_range &&
                         (run_q != IDLE) && !sec_block;

   always_comb begin
      if (ack_valid)   op = APT_ACTIVATE;
      else if (eoi_ok) op = APT_COMPLETE;
      else             op = APT_HOLD;
   end

   genvar g;
   for (g = 0; g < 2; g++) begin : g_bank
      apt_bank #(.NLEV(NLEV), .LVL_W(LVL_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_en  (op == APT_ACTIVATE && ack_bank == 1'(g)),
         .set_lvl (ack_lvl),
         .clr_en  (op == APT_COMPLETE && eoi_bank == 1'(g)),
         .q       (bank_q[g]),
         .d       (bank_d[g])
      );
   end

   apt_lsb_find #(.W(NLEV), .IDX_W(LVL_W)) u_find (
      .vec   (bank_d[0] | bank_d[1]),
      .found (low_found),
      .idx   (low_lvl)
   );

   always_comb begin
      unique case (op)
         APT_ACTIVATE: run_d = {1'b0, ack_prio};
         APT_COMPLETE: run_d = low_found ? {1'b0, low_lvl, {SHIFT{1'b0}}} : IDLE;
         default:      run_d = run_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= IDLE;
      else        run_q <= run_d;
   end

   assign run_prio = run_q;
   assign idle_o   = (run_q == IDLE);

endmodule

// File: rtl/active_prio_tracker_chk.sv
module active_prio_tracker_chk #(
   parameter int PRIO_W     = 8,
   parameter int MIN_BPR    = 0,
   parameter int NUM_IRQ    = 96,
   parameter int IRQ_W      = 10,
   parameter bit HAS_GROUPS = 1'b1,
   parameter bit SEC_EXT    = 1'b1,
   parameter int NLEV       = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_valid,
   input logic [PRIO_W-1:0] ack_prio,
   input logic              ack_grp1,
   input logic              eoi_valid,
   input logic [IRQ_W-1:0]  eoi_irq,
   input logic              eoi_grp1,
   input logic              eoi_secure,
   input logic [PRIO_W:0]   run_prio,
   input logic              idle_o,
   input logic [NLEV-1:0]   g0_bits,
   input logic [NLEV-1:0]   g1_bits
);
   localparam int SHIFT = MIN_BPR + 1;

   logic eoi_only;
   logic eoi_named_g1;
   logic eoi_take;
   int   active_cnt;

   assign eoi_only     = eoi_valid && !ack_valid;
   assign eoi_named_g1 = HAS_GROUPS && eoi_grp1;
   assign eoi_take     = eoi_only && (int'(eoi_irq) < NUM_IRQ) && !idle_o &&
                         !(SEC_EXT && !eoi_secure && !eoi_named_g1);
   assign active_cnt   = $countones(g0_bits) + $countones(g1_bits);

   a_r2_ack_priority: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> (run_prio == {1'b0, $past(ack_prio)}) && !idle_o);

   a_r3_ack_level_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> ((HAS_GROUPS && $past(ack_grp1))
                     ? g1_bits[$past(ack_prio[PRIO_W-1:SHIFT])]
                     : g0_bits[$past(ack_prio[PRIO_W-1:SHIFT])]));

   a_r4_pop_never_adds: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_take |=> active_cnt <= $past(active_cnt));

   a_r5_empty_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_take |=> (((g0_bits | g1_bits) == '0) == idle_o));

   a_r6_idle_eoi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_only && idle_o) |=> $stable(run_prio) && $stable(g0_bits) && $stable(g1_bits));

   a_r7_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_only && int'(eoi_irq) >= NUM_IRQ) |=> $stable(run_prio) && $stable(g0_bits) && $stable(g1_bits));

   a_r8_secure_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (SEC_EXT && eoi_only && !eoi_secure && !eoi_named_g1)
      |=> $stable(run_prio) && $stable(g0_bits) && $stable(g1_bits));

   a_r9_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && eoi_valid) |=> active_cnt >= $past(active_cnt));

endmodule

bind active_prio_tracker active_prio_tracker_chk #(
   .PRIO_W     (PRIO_W),
   .MIN_BPR    (MIN_BPR),
   .NUM_IRQ    (NUM_IRQ),
   .IRQ_W      (IRQ_W),
   .HAS_GROUPS (HAS_GROUPS),
   .SEC_EXT    (SEC_EXT),
   .NLEV       (NLEV)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack_valid  (ack_valid),
   .ack_prio   (ack_prio),
   .ack_grp1   (ack_grp1),
   .eoi_valid  (eoi_valid),
   .eoi_irq    (eoi_irq),
   .eoi_grp1   (eoi_grp1),
   .eoi_secure (eoi_secure),
   .run_prio   (run_prio),
   .idle_o     (idle_o),
   .g0_bits    (bank_q[0]),
   .g1_bits    (bank_q[1])
);

// File: tb/active_prio_tracker_tb_top.sv
`timescale 1ns/1ps
module active_prio_tracker_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ack_valid;
   logic [7:0] ack_prio;
   logic       ack_grp1;
   logic       eoi_valid;
   logic [9:0] eoi_irq;
   logic       eoi_grp1;
   logic       eoi_secure;
   logic [8:0] run_prio;
   logic       idle_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [127:0] m_b0, m_b1;
   logic [8:0]   m_run;

   always #2.5 clk = ~clk;

   active_prio_tracker dut_i (
      .clk(clk), .rst_n(rst_n),
      .ack_valid(ack_valid), .ack_prio(ack_prio), .ack_grp1(ack_grp1),
      .eoi_valid(eoi_valid), .eoi_irq(eoi_irq), .eoi_grp1(eoi_grp1),
      .eoi_secure(eoi_secure), .run_prio(run_prio), .idle_o(idle_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic check_out(input string tag);
      chk({tag, " run_prio"}, int'(run_prio), int'(m_run));
      chk({tag, " idle"}, int'(idle_o), int'(m_run == 9'h100));
   endtask

   function automatic logic [8:0] m_recalc();
      for (int i = 0; i < 128; i++)
         if (m_b0[i] | m_b1[i]) return 9'(i * 2);
      return 9'h100;
   endfunction

   function automatic logic [127:0] m_pop(input logic [127:0] v);
      for (int i = 0; i < 128; i++)
         if (v[i]) begin
            v[i] = 1'b0;
            return v;
         end
      return v;
   endfunction

   function automatic void m_ack(input logic [7:0] p, input logic g);
      if (g) m_b1[p[7:1]] = 1'b1;
      else   m_b0[p[7:1]] = 1'b1;
      m_run = {1'b0, p};
   endfunction

   function automatic void m_eoi(input int irq, input logic g, input logic sec);
      if (irq >= 96 || m_run == 9'h100 || (!sec && !g)) return;
      if (g) m_b1 = m_pop(m_b1);
      else   m_b0 = m_pop(m_b0);
      m_run = m_recalc();
   endfunction

   task automatic do_ack(input logic [7:0] p, input logic g);
      ack_valid = 1'b1; ack_prio = p; ack_grp1 = g;
      @(negedge clk);
      ack_valid = 1'b0;
      m_ack(p, g);
   endtask

   task automatic do_eoi(input int irq, input logic g, input logic sec);
      eoi_valid = 1'b1; eoi_irq = 10'(irq); eoi_grp1 = g; eoi_secure = sec;
      @(negedge clk);
      eoi_valid = 1'b0;
      m_eoi(irq, g, sec);
   endtask

   task automatic do_both(input logic [7:0] p, input logic g, input logic eg);
      ack_valid = 1'b1; ack_prio = p; ack_grp1 = g;
      eoi_valid = 1'b1; eoi_irq = 10'd1; eoi_grp1 = eg; eoi_secure = 1'b1;
      @(negedge clk);
      ack_valid = 1'b0; eoi_valid = 1'b0;
      m_ack(p, g);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ack_valid = 1'b0; ack_prio = '0; ack_grp1 = 1'b0;
      eoi_valid = 1'b0; eoi_irq = '0; eoi_grp1 = 1'b0; eoi_secure = 1'b1;
      m_b0 = '0; m_b1 = '0; m_run = 9'h100;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 reset");

      // R6: completion while idle
      do_eoi(5, 1'b1, 1'b1);
      check_out("R6 idle eoi");

      // R2/R3/R5: every level alone, alternating group, odd and even priorities
      for (int lvl = 0; lvl < 128; lvl++) begin
         logic [7:0] p;
         p = 8'(lvl * 2 + (lvl & 1));
         do_ack(p, 1'(lvl & 1));
         check_out("R2 R3 level ack");
         do_eoi(3, 1'(lvl & 1), 1'b1);
         check_out("R5 level eoi");
      end

      // R3/R4: nested stack across both banks, shared level 16
      do_ack(8'hF0, 1'b0); check_out("R2 nest");
      do_ack(8'hA1, 1'b1); check_out("R2 nest");
      do_ack(8'h60, 1'b0); check_out("R2 nest");
      do_ack(8'h20, 1'b1); check_out("R2 nest");
      do_ack(8'h21, 1'b0); check_out("R2 nest");
      do_eoi(10, 1'b1, 1'b1); check_out("R4 pop g1 shared level");
      do_eoi(10, 1'b1, 1'b1); check_out("R4 pop g1 deep");
      do_eoi(10, 1'b1, 1'b1); check_out("R4 pop empty bank");
      do_eoi(10, 1'b0, 1'b1); check_out("R4 pop g0");
      do_eoi(10, 1'b0, 1'b1); check_out("R4 pop g0");
      do_eoi(10, 1'b0, 1'b1); check_out("R5 pop last");

      // R7: interrupt number range
      do_ack(8'h40, 1'b1);
      do_eoi(96, 1'b1, 1'b1); check_out("R7 irq 96 ignored");
      do_eoi(95, 1'b1, 1'b1); check_out("R7 irq 95 accepted");

      // R8: security filter
      do_ack(8'h41, 1'b0);
      do_eoi(7, 1'b0, 1'b0); check_out("R8 nonsecure g0 ignored");
      do_eoi(7, 1'b1, 1'b0); check_out("R8 nonsecure g1 recompute");
      do_eoi(7, 1'b0, 1'b1); check_out("R8 secure g0 accepted");

      // R9: simultaneous strobes
      do_ack(8'h80, 1'b0);
      do_both(8'h30, 1'b1, 1'b0); check_out("R9 ack wins");
      do_eoi(2, 1'b1, 1'b1); check_out("R9 g1 popped");
      do_eoi(2, 1'b0, 1'b1); check_out("R9 g0 kept then popped");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule